// File: doc/BRIEF.md
# Serial Controller Register Access and Modem Control

This block is the processor-side register front end of a serial communications controller. Each cycle with chip enable high is one access. The access direction and a two-bit address pick the target. Several registers share one address, and internal pointers step through them on successive accesses. The block also holds the command register, which drives the data-terminal-ready and request-to-send outputs. It builds a status byte from the modem inputs and a transmitter-empty flag.

The data-set-ready and carrier-detect pins are active low. Each passes through a two-flop synchronizer and then an edge detector. Any change on either pin sets a shared change flag. That flag and the transmitter-empty input from the transmit datapath are combined onto one active-low output. A status read clears the flag. The serial datapaths themselves are not part of this block. The block hands them the synchronization, link-escape, mode and command bytes on plain output ports, together with a receiver-enable qualifier.

Accesses are single-cycle, with no back-pressure. The block accepts an access in every cycle that `ce` is high. Read data is combinational from the registers and is valid in the same cycle as the access.

Top module: `sci_regif`

## Requirements
- R1: After reset, `dtr_n`, `rts_n` and `txemt_dschg_n` are 1 (with `txemt` low), `rx_en` is 0, all stored bytes are 0 and both pointers select their first register.
- R2: Address decode applies when `ce`=1, where `rw`=1 means write. Address 1 writes go to the SYN/DLE sequence and address 1 reads return status. Address 2 is the mode pair and address 3 is the command register. Address 0 is ignored and reads as 0x00. With `ce`=0 nothing changes.
- R3: Successive writes to address 1 load the first sync byte, then the second sync byte, then the link-escape byte, and the pointer then wraps back to the first sync byte.
- R4: Accesses to address 2, read or write, alternate between mode byte 1 and mode byte 2 through one shared pointer. A write loads the selected byte and a read returns it.
- R5: Any command register access, read or write, returns both pointers to their first register.
- R6: `dtr_n` is the inverse of command bit 1 and `rts_n` is the inverse of command bit 5. Both take effect the cycle after the write.
- R7: Status bit 7 is the inverse of the synchronized `dsr_n` and bit 6 is the inverse of the synchronized `dcd_n`. Bit 2 is the change flag and bit 0 is `txemt`. All other status bits are 0. A pin change shows in status after two clock edges.
- R8: A change on `dsr_n` or `dcd_n` sets the change flag on the third clock edge after the pin change, and `txemt_dschg_n` goes low.
- R9: A status read clears the change flag. If a new change is detected in the same cycle as the read, the flag stays set.
- R10: `txemt_dschg_n` is low whenever `txemt` is 1.
- R11: `rx_en` is 1 only while command bit 2 is 1 and the synchronized `dcd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Access strobe, one access per cycle high |
| rw | input | 1 | 1 = write, 0 = read |
| a | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the access cycle |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| txemt | input | 1 | Transmitter-empty flag from the transmit datapath |
| txemt_dschg_n | output | 1 | Low on transmitter empty or modem change |
| dtr_n | output | 1 | Data-terminal-ready output |
| rts_n | output | 1 | Request-to-send output |
| rx_en | output | 1 | Receiver enable qualifier |
| syn1 | output | 8 | First sync byte |
| syn2 | output | 8 | Second sync byte |
| dle | output | 8 | Link-escape byte |
| mode1 | output | 8 | Mode byte 1 |
| mode2 | output | 8 | Mode byte 2 |
| cmd | output | 8 | Command byte |

## Verification
Some properties are checked on every cycle:
- the SYN pointer stays in range;
- a command access clears both pointers;
- a first-slot write lands in the first sync byte;
- command writes reach the modem outputs;
- a detected change pulls the combined output low;
- an undisturbed status read clears the flag.

Only the bench scenarios show the other behaviours. These are the full order of shared-address accesses, including wrap and pointer reset, and the exact synchronizer latency counted in edges. They also include the flag set winning over a status read that lands in the same cycle, and the state after a reset part-way through a sequence.

// File: rtl/sci_regif_pkg.sv
package sci_regif_pkg;
  typedef enum logic [1:0] {
    ADR_DATA    = 2'd0,
    ADR_SYNSTAT = 2'd1,
    ADR_MODE    = 2'd2,
    ADR_CMD     = 2'd3
  } adr_e;

  localparam int CMD_DTR  = 1;
  localparam int CMD_RXEN = 2;
  localparam int CMD_RTS  = 5;

  localparam int ST_DSR = 7;
  localparam int ST_DCD = 6;
  localparam int ST_CHG = 2;
  localparam int ST_EMT = 0;

  localparam int NUM_MODEM = 2;
  localparam int MDM_DSR   = 0;
  localparam int MDM_DCD   = 1;
endpackage

// File: rtl/modem_watch.sv
module modem_watch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl_n,
  output logic chg
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_n = sync_q[STAGES-1];
  assign chg   = lvl_n ^ prev_q;

  assert_edge_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (prev_q == $past(lvl_n)));
endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int DW     = 8,
  parameter int NUM_SD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sd_wr,
  input  logic          mode_acc,
  input  logic          mode_wr,
  input  logic          ptr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] syn1,
  output logic [DW-1:0] syn2,
  output logic [DW-1:0] dle,
  output logic [DW-1:0] mode1,
  output logic [DW-1:0] mode2,
  output logic [DW-1:0] mode_rdata
);
  localparam int PW = $clog2(NUM_SD);

  logic [DW-1:0] sd_q [NUM_SD];
  logic [PW-1:0] sd_ptr;
  logic [DW-1:0] mode_q [2];
  logic          mode_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_ptr <= '0;
      for (int i = 0; i < NUM_SD; i++) sd_q[i] <= '0;
    end else if (ptr_clr) begin
      sd_ptr <= '0;
    end else if (sd_wr) begin
      sd_q[sd_ptr] <= wdata;
      sd_ptr <= (sd_ptr == PW'(NUM_SD-1)) ? '0 : sd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ptr  <= 1'b0;
      mode_q[0] <= '0;
      mode_q[1] <= '0;
    end else if (ptr_clr) begin
      mode_ptr <= 1'b0;
    end else if (mode_acc) begin
      if (mode_wr) mode_q[mode_ptr] <= wdata;
      mode_ptr <= ~mode_ptr;
    end
  end

  assign syn1       = sd_q[0];
  assign syn2       = sd_q[1];
  assign dle        = sd_q[NUM_SD-1];
  assign mode1      = mode_q[0];
  assign mode2      = mode_q[1];
  assign mode_rdata = mode_q[mode_ptr];

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_ptr < PW'(NUM_SD));
  assert_first_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_wr && !ptr_clr && sd_ptr == '0) |=> (syn1 == $past(wdata)));
  assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (sd_ptr == '0 && !mode_ptr));
  assert_mode_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_acc && !ptr_clr) |=> (mode_ptr != $past(mode_ptr)));
endmodule

// File: rtl/sci_regif.sv
module sci_regif
  import sci_regif_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          rw,
  input  logic [1:0]    a,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          dsr_n,
  input  logic          dcd_n,
  input  logic          txemt,
  output logic          txemt_dschg_n,
  output logic          dtr_n,
  output logic          rts_n,
  output logic          rx_en,
  output logic [DW-1:0] syn1,
  output logic [DW-1:0] syn2,
  output logic [DW-1:0] dle,
  output logic [DW-1:0] mode1,
  output logic [DW-1:0] mode2,
  output logic [DW-1:0] cmd
);
  adr_e adr;
  logic acc_cmd, acc_mode, sd_wr, st_rd;
  logic [NUM_MODEM-1:0] pin_n, lvl_n, chg;
  logic any_chg, chg_flag;
  logic [DW-1:0] cmd_q, status, mode_rdata;

  assign adr      = adr_e'(a);
  assign acc_cmd  = ce && (adr == ADR_CMD);
  assign acc_mode = ce && (adr == ADR_MODE);
  assign sd_wr    = ce && rw && (adr == ADR_SYNSTAT);
  assign st_rd    = ce && !rw && (adr == ADR_SYNSTAT);

  assign pin_n[MDM_DSR] = dsr_n;
  assign pin_n[MDM_DCD] = dcd_n;

  for (genvar g = 0; g < NUM_MODEM; g++) begin : g_mdm
    modem_watch #(.STAGES(SYNC_STAGES)) u_watch (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_n(pin_n[g]),
      .lvl_n(lvl_n[g]),
      .chg  (chg[g])
    );
  end

  assign any_chg = |chg;

  seq_regs #(.DW(DW), .NUM_SD(3)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_wr     (sd_wr),
    .mode_acc  (acc_mode),
    .mode_wr   (rw),
    .ptr_clr   (acc_cmd),
    .wdata     (wdata),
    .syn1      (syn1),
    .syn2      (syn2),
    .dle       (dle),
    .mode1     (mode1),
    .mode2     (mode2),
    .mode_rdata(mode_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (acc_cmd && rw) cmd_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_flag <= 1'b0;
    else if (any_chg) chg_flag <= 1'b1;
    else if (st_rd) chg_flag <= 1'b0;
  end

  always_comb begin
    status         = '0;
    status[ST_DSR] = ~lvl_n[MDM_DSR];
    status[ST_DCD] = ~lvl_n[MDM_DCD];
    status[ST_CHG] = chg_flag;
    status[ST_EMT] = txemt;
  end

  always_comb begin
    rdata = '0;
    if (ce && !rw) begin
      unique case (adr)
        ADR_SYNSTAT: rdata = status;
        ADR_MODE:    rdata = mode_rdata;
        ADR_CMD:     rdata = cmd_q;
        default:     rdata = '0;
      endcase
    end
  end

  assign cmd           = cmd_q;
  assign dtr_n         = ~cmd_q[CMD_DTR];
  assign rts_n         = ~cmd_q[CMD_RTS];
  assign rx_en         = cmd_q[CMD_RXEN] & ~lvl_n[MDM_DCD];
  assign txemt_dschg_n = ~(txemt | chg_flag);

  assert_cmd_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cmd && rw) |=> (dtr_n == !$past(wdata[CMD_DTR]) && rts_n == !$past(wdata[CMD_RTS])));
  assert_chg_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_chg |=> !txemt_dschg_n);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !any_chg) |=> !chg_flag);
  assert_emt_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txemt |-> !txemt_dschg_n);
  assert_rx_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[CMD_RXEN] |-> !rx_en);
endmodule

// File: tb/sci_regif_tb.sv
`timescale 1ns/1ps
module sci_regif_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, rw = 1'b0;
  logic [1:0] a = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic dsr_n = 1'b1, dcd_n = 1'b1, txemt = 1'b0;
  logic txemt_dschg_n, dtr_n, rts_n, rx_en;
  logic [7:0] syn1, syn2, dle, mode1, mode2, cmd;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sci_regif u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .rw(rw), .a(a), .wdata(wdata),
    .rdata(rdata), .dsr_n(dsr_n), .dcd_n(dcd_n), .txemt(txemt),
    .txemt_dschg_n(txemt_dschg_n), .dtr_n(dtr_n), .rts_n(rts_n),
    .rx_en(rx_en), .syn1(syn1), .syn2(syn2), .dle(dle),
    .mode1(mode1), .mode2(mode2), .cmd(cmd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] ad, input logic [7:0] d,
                     output logic [7:0] rd);
    @(negedge clk);
    ce = 1'b1; rw = w; a = ad; wdata = d;
    #1 rd = rdata;
    @(negedge clk);
    ce = 1'b0; rw = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // fields: rw, addr, wdata, check, expected read
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd1, 8'h16, 1'b0, 8'h00},
    {1'b1, 2'd1, 8'h5A, 1'b0, 8'h00},
    {1'b1, 2'd1, 8'h10, 1'b0, 8'h00},
    {1'b1, 2'd1, 8'hAA, 1'b0, 8'h00},
    {1'b1, 2'd2, 8'h4E, 1'b0, 8'h00},
    {1'b1, 2'd2, 8'h37, 1'b0, 8'h00},
    {1'b0, 2'd2, 8'h00, 1'b1, 8'h4E},
    {1'b0, 2'd2, 8'h00, 1'b1, 8'h37},
    {1'b1, 2'd2, 8'h11, 1'b0, 8'h00},
    {1'b1, 2'd3, 8'h27, 1'b0, 8'h00},
    {1'b1, 2'd2, 8'hC3, 1'b0, 8'h00},
    {1'b0, 2'd2, 8'h00, 1'b1, 8'h37},
    {1'b0, 2'd3, 8'h00, 1'b1, 8'h27},
    {1'b1, 2'd1, 8'h77, 1'b0, 8'h00},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'h00},
    {1'b1, 2'd0, 8'hFF, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'h00, 1'b1, 8'h00}
  };

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    edges(2);
    rst_n = 1'b1;
    edges(1);
    // R1 reset state
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
    chk("R1 rts_n", {7'd0, rts_n}, 8'h01);
    chk("R1 txemt_dschg_n", {7'd0, txemt_dschg_n}, 8'h01);
    chk("R1 rx_en", {7'd0, rx_en}, 8'h00);
    chk("R1 syn1", syn1, 8'h00);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][19], VEC[i][18:17], VEC[i][16:9], rd);
      if (VEC[i][8]) chk($sformatf("R2/R4/R5 vec%0d rdata", i), rd, VEC[i][7:0]);
    end
    chk("R5 syn1 after cmd clear", syn1, 8'h77);
    chk("R3 syn2", syn2, 8'h5A);
    chk("R3 dle", dle, 8'h10);
    chk("R5 mode1 after cmd clear", mode1, 8'hC3);
    chk("R4 mode2", mode2, 8'h37);
    chk("R6 dtr_n", {7'd0, dtr_n}, 8'h00);
    chk("R6 rts_n", {7'd0, rts_n}, 8'h00);
    chk("R11 rx_en dcd high", {7'd0, rx_en}, 8'h00);

    // R2 ce low ignored
    @(negedge clk);
    ce = 1'b0; rw = 1'b1; a = 2'd3; wdata = 8'h00;
    edges(1);
    rw = 1'b0;
    chk("R2 ce low cmd kept", cmd, 8'h27);

    // R6 clear DTR only
    acc(1'b1, 2'd3, 8'h25, rd);
    chk("R6 dtr_n high", {7'd0, dtr_n}, 8'h01);
    chk("R6 rts_n low", {7'd0, rts_n}, 8'h00);

    // R7 R8 R11 dcd falls
    @(negedge clk); dcd_n = 1'b0;
    edges(1);
    chk("R11 rx_en after one edge", {7'd0, rx_en}, 8'h00);
    edges(1);
    chk("R11 rx_en after two edges", {7'd0, rx_en}, 8'h01);
    chk("R8 no flag yet", {7'd0, txemt_dschg_n}, 8'h01);
    edges(1);
    chk("R8 flag after three edges", {7'd0, txemt_dschg_n}, 8'h00);
    acc(1'b0, 2'd1, 8'h00, rd);
    chk("R7 status dcd+chg", rd, 8'h44);
    chk("R9 cleared", {7'd0, txemt_dschg_n}, 8'h01);
    acc(1'b0, 2'd1, 8'h00, rd);
    chk("R9 status after clear", rd, 8'h40);

    // R7 dsr falls
    @(negedge clk); dsr_n = 1'b0;
    edges(4);
    acc(1'b0, 2'd1, 8'h00, rd);
    chk("R7 status dsr+dcd+chg", rd, 8'hC4);

    // R10 txemt
    @(negedge clk); txemt = 1'b1; #1;
    chk("R10 txemt low out", {7'd0, txemt_dschg_n}, 8'h00);
    acc(1'b0, 2'd1, 8'h00, rd);
    chk("R7 status emt bit", rd, 8'hC1);
    @(negedge clk); txemt = 1'b0; #1;
    chk("R10 txemt released", {7'd0, txemt_dschg_n}, 8'h01);

    // R9 change detected in same cycle as status read: set wins
    @(negedge clk); dsr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ce = 1'b1; rw = 1'b0; a = 2'd1;
    @(negedge clk);
    ce = 1'b0;
    #1;
    chk("R9 set wins over read", {7'd0, txemt_dschg_n}, 8'h00);

    // R1 R3 reset mid sequence
    acc(1'b1, 2'd1, 8'h01, rd);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 cmd after reset", cmd, 8'h00);
    acc(1'b1, 2'd1, 8'h99, rd);
    chk("R1 sd pointer at first after reset", syn1, 8'h99);
    chk("R1 syn2 zero", syn2, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule